// File: doc/BRIEF.md
# Bit-Band Alias Translator

This block sits between a bus requester and the backing bus that serves the SRAM and peripheral regions. It recognises accesses to two alias windows, where each 32-bit alias word stands for one bit of the backing region. An alias read fetches the backing word and returns the chosen bit as a value of 0 or 1. An alias write turns into a locked read-modify-write of the backing word that changes only that bit, and takes its new value from bit 0 of the write data. An instruction fetch from an alias window is refused with an error and never reaches the backing bus.

Any address outside the two windows goes straight through to the backing bus. It has no added register stage, so the requester sees the backing bus's own timing. Both sides use the same handshake: a request is held until `req_ready` (or `mem_ready` on the backing side) is high in a clock cycle, and the response data is valid in that same cycle. Window bases, span, data width and byte-lane order are parameters.

Top module: `bitband_xlate`

## Requirements
- R1: A request is an alias access exactly when its address lies in 0x2200_0000..0x23FF_FFFF (backed by the region at 0x2000_0000) or in 0x4200_0000..0x43FF_FFFF (backed by the region at 0x4000_0000). Every other address is a pass-through access.
- R2: For an alias offset `off` (address minus window base), the backing byte is base + (off >> 5) and the bit within that byte is (off >> 2) & 7. The backing access uses that byte address with its two low bits cleared. The bit position in the 32-bit word is lane*8 + bit, where lane is the byte address's two low bits (little-endian lanes by default).
- R3: An alias read (kind 2'b00) completes with `rsp_rdata` = 0x0000_0001 when the target bit is set and 0x0000_0000 when it is clear, and with `rsp_err` low.
- R4: An alias write (kind 2'b01) performs a backing read and then a backing write of the same word. The write data equals the word that was read, with only the target bit replaced by `req_wdata[0]`.
- R5: `mem_lock` is high on both backing accesses of an alias write and in every cycle between them. It is low on alias reads and on pass-through accesses.
- R6: An instruction fetch (kind 2'b10) to an alias window completes in the cycle it is presented, with `rsp_err` high and `rsp_rdata` zero, and makes no backing access.
- R7: An alias read makes exactly one backing access and completes after 2+W cycles. An alias write makes exactly two and completes after 3+2W cycles. W is the number of wait cycles per backing access.
- R8: A pass-through access drives `mem_addr`, `mem_write` (high for kind 2'b01) and `mem_wdata` from the request in the same cycle. It returns `mem_rdata` and completes in the cycle `mem_ready` is high, i.e. after 1+W cycles.
- R9: After reset, and whenever no request is pending, `mem_valid`, `mem_lock` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_kind | input | 2 | 00 read, 01 write, 10 instruction fetch |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Write data (bit 0 used for alias writes) |
| req_ready | output | 1 | Request completes this cycle |
| rsp_err | output | 1 | Error response, valid with req_ready |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| mem_valid | output | 1 | Backing access present |
| mem_write | output | 1 | Backing access is a write |
| mem_lock | output | 1 | Backing bus locked for a read-modify-write |
| mem_addr | output | 32 | Backing byte address |
| mem_wdata | output | 32 | Backing write data |
| mem_ready | input | 1 | Backing access completes this cycle |
| mem_rdata | input | 32 | Backing read data, valid with mem_ready |

## Verification
Most faults in the sequencer show up within a single alias access. A state stuck in the read phase, or a merged word that was latched wrongly, gives a wrong word in the backing memory or an extra or missing backing access. The bench catches these by re-reading the word through the pass-through path and by counting accesses and cycles for each request. A lock that drops between the two phases shows as an unlocked `mem_valid` cycle inside a write sequence. A wrong window decode or bit position shows at once as a wrong `mem_addr` or a wrong 0/1 result on the very next alias read.

// File: rtl/bb_pkg.sv
package bb_pkg;

   typedef enum logic [1:0] {
      KIND_READ  = 2'b00,
      KIND_WRITE = 2'b01,
      KIND_FETCH = 2'b10
   } bb_kind_e;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'b00,
      SEQ_READ  = 2'b01,
      SEQ_WRITE = 2'b10
   } bb_seq_e;

   function automatic bit bb_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bb_decode.sv
module bb_decode #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NUM_WIN    = 2,
   parameter int SPAN_LOG2  = 25,
   parameter bit BIG_ENDIAN = 1'b0,
   parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
   parameter logic [NUM_WIN*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000},
   localparam int POS_W  = $clog2(DATA_W),
   localparam int LANE_W = POS_W - 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [ADDR_W-1:0] word_addr,
   output logic [POS_W-1:0]  bitpos
);

   localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'((DATA_W / 8) - 1);

   logic [NUM_WIN-1:0]        win_hit;
   logic [ADDR_W-1:0]         win_addr [NUM_WIN];
   logic [POS_W-1:0]          win_pos  [NUM_WIN];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] ABASE = ALIAS_BASES[w*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] BBASE = BACK_BASES[w*ADDR_W +: ADDR_W];

      if (ABASE[SPAN_LOG2-1:0] != '0) begin : g_bad_align
         $error("alias base %0d not aligned to its span", w);
      end

      logic [SPAN_LOG2-1:0] off;
      logic [ADDR_W-1:0]    byte_addr;
      logic [LANE_W-1:0]    lane;

      assign off       = addr[SPAN_LOG2-1:0];
      assign win_hit[w] = (addr[ADDR_W-1:SPAN_LOG2] == ABASE[ADDR_W-1:SPAN_LOG2]);
      assign byte_addr = BBASE + ADDR_W'(off >> 5);
      assign win_addr[w] = byte_addr & ~LANE_MASK;

      if (BIG_ENDIAN) begin : g_be
         assign lane = ~byte_addr[LANE_W-1:0];
      end else begin : g_le
         assign lane = byte_addr[LANE_W-1:0];
      end

      assign win_pos[w] = {lane, off[4:2]};
   end

   // lowest-numbered window wins if windows ever overlap
   always_comb begin
      hit       = 1'b0;
      word_addr = '0;
      bitpos    = '0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (win_hit[w]) begin
            hit       = 1'b1;
            word_addr = win_addr[w];
            bitpos    = win_pos[w];
         end
      end
   end

endmodule

// File: rtl/bb_bitops.sv
module bb_bitops #(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] word_in,
   input  logic [POS_W-1:0]  pos,
   input  logic              new_bit,
   output logic              cur_bit,
   output logic [DATA_W-1:0] word_out
);

   always_comb begin
      cur_bit       = word_in[pos];
      word_out      = word_in;
      word_out[pos] = new_bit;
   end

endmodule

// File: rtl/bb_seq.sv
module bb_seq
   import bb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_write,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [POS_W-1:0]  start_pos,
   input  logic              start_bit,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              seq_valid,
   output logic              seq_write,
   output logic              seq_lock,
   output logic [ADDR_W-1:0] seq_addr,
   output logic [DATA_W-1:0] seq_wdata,
   output logic              done,
   output logic              done_bit
);

   bb_seq_e           state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [POS_W-1:0]  pos_q;
   logic              bit_q;
   logic              wr_q;
   logic [DATA_W-1:0] merged_q;
   logic [DATA_W-1:0] merged_d;
   logic              picked;

   bb_bitops #(.DATA_W(DATA_W)) u_bitops (
      .word_in  (mem_rdata),
      .pos      (pos_q),
      .new_bit  (bit_q),
      .cur_bit  (picked),
      .word_out (merged_d)
   );

   always_comb begin
      state_d = state_q;
      done    = 1'b0;
      unique case (state_q)
         SEQ_IDLE: begin
            if (start) state_d = SEQ_READ;
         end
         SEQ_READ: begin
            if (mem_ready) begin
               if (wr_q) begin
                  state_d = SEQ_WRITE;
               end else begin
                  state_d = SEQ_IDLE;
                  done    = 1'b1;
               end
            end
         end
         SEQ_WRITE: begin
            if (mem_ready) begin
               state_d = SEQ_IDLE;
               done    = 1'b1;
            end
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         addr_q   <= '0;
         pos_q    <= '0;
         bit_q    <= 1'b0;
         wr_q     <= 1'b0;
         merged_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == SEQ_IDLE && start) begin
            addr_q <= start_addr;
            pos_q  <= start_pos;
            bit_q  <= start_bit;
            wr_q   <= start_write;
         end
         if (state_q == SEQ_READ && mem_ready) begin
            merged_q <= merged_d;
         end
      end
   end

   assign busy      = (state_q != SEQ_IDLE);
   assign seq_valid = busy;
   assign seq_write = (state_q == SEQ_WRITE);
   assign seq_lock  = busy && wr_q;
   assign seq_addr  = addr_q;
   assign seq_wdata = merged_q;
   assign done_bit  = picked;

endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
   import bb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NUM_WIN    = 2,
   parameter int SPAN_LOG2  = 25,
   parameter bit BIG_ENDIAN = 1'b0,
   parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
   parameter logic [NUM_WIN*ADDR_W-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_valid,
   output logic              mem_write,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int POS_W = $clog2(DATA_W);

   if (!bb_is_pow2(DATA_W) || DATA_W < 16) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 16");
   end
   if (SPAN_LOG2 <= 5 || SPAN_LOG2 >= ADDR_W) begin : g_bad_span
      $error("SPAN_LOG2 must lie between 6 and ADDR_W-1");
   end
   if (NUM_WIN < 1) begin : g_bad_win
      $error("NUM_WIN must be at least 1");
   end

   logic              hit;
   logic [ADDR_W-1:0] xl_addr;
   logic [POS_W-1:0]  xl_pos;
   logic              busy;
   logic              seq_valid, seq_write, seq_lock;
   logic [ADDR_W-1:0] seq_addr;
   logic [DATA_W-1:0] seq_wdata;
   logic              seq_done, seq_bit;
   logic              is_fetch, is_write, alias_go, fetch_rej;

   bb_decode #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .NUM_WIN     (NUM_WIN),
      .SPAN_LOG2   (SPAN_LOG2),
      .BIG_ENDIAN  (BIG_ENDIAN),
      .ALIAS_BASES (ALIAS_BASES),
      .BACK_BASES  (BACK_BASES)
   ) u_decode (
      .addr      (req_addr),
      .hit       (hit),
      .word_addr (xl_addr),
      .bitpos    (xl_pos)
   );

   assign is_fetch  = (req_kind == KIND_FETCH);
   assign is_write  = (req_kind == KIND_WRITE);
   assign alias_go  = req_valid && hit && !is_fetch && !busy;
   assign fetch_rej = req_valid && hit && is_fetch && !busy;

   bb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (alias_go),
      .start_write (is_write),
      .start_addr  (xl_addr),
      .start_pos   (xl_pos),
      .start_bit   (req_wdata[0]),
      .mem_ready   (mem_ready),
      .mem_rdata   (mem_rdata),
      .busy        (busy),
      .seq_valid   (seq_valid),
      .seq_write   (seq_write),
      .seq_lock    (seq_lock),
      .seq_addr    (seq_addr),
      .seq_wdata   (seq_wdata),
      .done        (seq_done),
      .done_bit    (seq_bit)
   );

   always_comb begin
      if (busy) begin
         mem_valid = seq_valid;
         mem_write = seq_write;
         mem_lock  = seq_lock;
         mem_addr  = seq_addr;
         mem_wdata = seq_wdata;
         req_ready = req_valid && seq_done;
         rsp_err   = 1'b0;
         rsp_rdata = (seq_done && !seq_write) ? DATA_W'(seq_bit) : '0;
      end else begin
         mem_valid = req_valid && !hit;
         mem_write = is_write;
         mem_lock  = 1'b0;
         mem_addr  = req_addr;
         mem_wdata = req_wdata;
         req_ready = hit ? fetch_rej : (req_valid && mem_ready);
         rsp_err   = fetch_rej;
         rsp_rdata = hit ? '0 : mem_rdata;
      end
   end

endmodule

// File: rtl/bitband_xlate_chk.sv
module bitband_xlate_chk #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int NUM_WIN   = 2,
   parameter int SPAN_LOG2 = 25,
   parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000}
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_kind,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_ready,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              mem_valid,
   input logic              mem_write,
   input logic              mem_lock,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ready,
   input logic              busy
);

   logic in_alias;

   always_comb begin
      in_alias = 1'b0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if ((req_addr >> SPAN_LOG2) == (ALIAS_BASES[w*ADDR_W +: ADDR_W] >> SPAN_LOG2))
            in_alias = 1'b1;
      end
   end

   // R6: alias fetches are refused at once and never reach the backing bus
   assert_fetch_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_alias && req_kind == 2'b10 && !busy)
         |-> (req_ready && rsp_err && !mem_valid));

   // R8: pass-through is combinational to the backing bus
   assert_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !in_alias && !busy)
         |-> (mem_valid && mem_addr == req_addr && req_ready == mem_ready && !mem_lock));

   // R5: the write phase of a read-modify-write is always locked
   assert_write_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_valid && mem_write) |-> mem_lock);

   // R4: a finished locked read is followed directly by the locked write
   assert_rmw_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_valid && mem_ready && !mem_write && mem_lock)
         |=> (mem_valid && mem_write && mem_lock));

   // R3: alias read results are 0 or 1 and never an error
   assert_read_format_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid && req_ready && !mem_lock)
         |-> (rsp_rdata <= DATA_W'(1) && !rsp_err));

   // R9: nothing is driven on the backing bus without a pending request
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |-> (!mem_valid && !mem_lock && !req_ready));

endmodule

bind bitband_xlate bitband_xlate_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .NUM_WIN     (NUM_WIN),
   .SPAN_LOG2   (SPAN_LOG2),
   .ALIAS_BASES (ALIAS_BASES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_kind  (req_kind),
   .req_addr  (req_addr),
   .req_ready (req_ready),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .mem_valid (mem_valid),
   .mem_write (mem_write),
   .mem_lock  (mem_lock),
   .mem_addr  (mem_addr),
   .mem_ready (mem_ready),
   .busy      (busy)
);

// File: tb/bitband_xlate_bench.sv
module bitband_xlate_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_err;
   logic [31:0] rsp_rdata;
   logic        mem_valid, mem_write, mem_lock;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ready;
   logic [31:0] mem_rdata;

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   bitband_xlate u_bitband_xlate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .mem_valid(mem_valid), .mem_write(mem_write),
      .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   // backing memory model: 64 words indexed by {addr[30], addr[6:2]}
   logic [31:0] bm [64];
   int          wait_cfg = 0;
   int          wcnt = 0;
   int          acc_cnt = 0;
   int          lk_cnt = 0;
   int          unlk_cycles = 0;
   logic [31:0] last_addr = '0;

   function automatic int bidx(input logic [31:0] a);
      return {a[30], a[6:2]};
   endfunction

   assign mem_ready = mem_valid && (wcnt == wait_cfg);
   always_comb mem_rdata = bm[bidx(mem_addr)];

   always @(posedge clk) begin
      if (mem_valid && !mem_ready) wcnt <= wcnt + 1;
      else                         wcnt <= 0;
      if (mem_valid && !mem_lock)  unlk_cycles <= unlk_cycles + 1;
      if (mem_valid && mem_ready) begin
         acc_cnt   <= acc_cnt + 1;
         last_addr <= mem_addr;
         if (mem_lock) lk_cnt <= lk_cnt + 1;
         if (mem_write) bm[bidx(mem_addr)] <= mem_wdata;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard
   typedef struct {
      logic [31:0] rdata;
      logic        err;
      bit          chk_rd;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   always @(negedge clk) begin
      if (rst_n && req_valid && req_ready) begin
         if (sbq.size() == 0) begin
            check("R3 unexpected response", 32'h1, 32'h0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            check({e.tag, " err"}, {31'b0, rsp_err}, {31'b0, e.err});
            if (e.chk_rd) check({e.tag, " rdata"}, rsp_rdata, e.rdata);
         end
      end
   end

   task automatic run(input logic [1:0] kind, input logic [31:0] addr,
                      input logic [31:0] wdata, input bit chk_rd,
                      input logic [31:0] exp_rd, input logic exp_err,
                      input int exp_cyc, input int exp_acc, input int exp_lk,
                      input string tag);
      int cyc, a0, l0, u0;
      bit done;
      exp_t e;
      e.rdata = exp_rd; e.err = exp_err; e.chk_rd = chk_rd; e.tag = tag;
      sbq.push_back(e);
      a0 = acc_cnt; l0 = lk_cnt; u0 = unlk_cycles;
      req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wdata;
      cyc = 0; done = 1'b0;
      while (!done) begin
         @(negedge clk);
         cyc++;
         done = req_ready;
         @(posedge clk);
         #1;
      end
      req_valid = 1'b0;
      check({tag, " R7/R8 cycles"}, cyc, exp_cyc);
      check({tag, " R7 accesses"}, acc_cnt - a0, exp_acc);
      check({tag, " R5 locked accesses"}, lk_cnt - l0, exp_lk);
      if (exp_lk != 0) check({tag, " R5 unlocked cycles"}, unlk_cycles - u0, 0);
   endtask

   task automatic pwrite(input logic [31:0] a, input logic [31:0] d);
      run(2'b01, a, d, 1'b0, '0, 1'b0, 1 + wait_cfg, 1, 0, "R8 pass write");
   endtask

   task automatic pread(input logic [31:0] a, input logic [31:0] exp, input string tag);
      run(2'b00, a, '0, 1'b1, exp, 1'b0, 1 + wait_cfg, 1, 0, tag);
      check({tag, " R8 address"}, last_addr, a);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) bm[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset mem_valid", {31'b0, mem_valid}, 32'h0);
      check("R9 reset mem_lock",  {31'b0, mem_lock},  32'h0);
      check("R9 reset req_ready", {31'b0, req_ready}, 32'h0);
      @(posedge clk); #1;

      // pass-through, zero wait
      pwrite(32'h2000_0010, 32'h0000_8001);
      pread(32'h2000_0010, 32'h0000_8001, "R8 pass read");

      // alias reads of SRAM bits (R2, R3)
      run(2'b00, 32'h2200_0200, '0, 1'b1, 32'h1, 1'b0, 2, 1, 0, "R3 bit0 set");
      check("R2 alias word addr", last_addr, 32'h2000_0010);
      run(2'b00, 32'h2200_0204, '0, 1'b1, 32'h0, 1'b0, 2, 1, 0, "R3 bit1 clear");
      run(2'b00, 32'h2200_023C, '0, 1'b1, 32'h1, 1'b0, 2, 1, 0, "R2 lane1 bit7");
      check("R2 lane1 word addr", last_addr, 32'h2000_0010);

      // alias write sets lane2 bit3 -> word bit 19 (R4)
      run(2'b01, 32'h2200_024C, 32'h1, 1'b1, 32'h0, 1'b0, 3, 2, 2, "R4 set bit");
      check("R4 write word addr", last_addr, 32'h2000_0010);
      pread(32'h2000_0010, 32'h0008_8001, "R4 after set");
      // clear bit0 using bit 0 of wdata only
      run(2'b01, 32'h2200_0200, 32'hFFFF_FFFE, 1'b1, 32'h0, 1'b0, 3, 2, 2, "R4 clear bit");
      pread(32'h2000_0010, 32'h0008_8000, "R4 after clear");

      // peripheral window (R1, R2)
      pwrite(32'h4000_0020, 32'h0000_0000);
      run(2'b01, 32'h4200_0428, 32'h1, 1'b1, 32'h0, 1'b0, 3, 2, 2, "R2 periph set");
      check("R2 periph word addr", last_addr, 32'h4000_0020);
      pread(32'h4000_0020, 32'h0000_0400, "R2 periph word");
      run(2'b00, 32'h4200_0428, '0, 1'b1, 32'h1, 1'b0, 2, 1, 0, "R3 periph read");

      // top of SRAM alias window -> byte 0x200F_FFFF bit 7
      pwrite(32'h200F_FFFC, 32'h8000_0000);
      run(2'b00, 32'h23FF_FFFC, '0, 1'b1, 32'h1, 1'b0, 2, 1, 0, "R2 window top");
      check("R2 top word addr", last_addr, 32'h200F_FFFC);

      // fetches (R6)
      run(2'b10, 32'h2200_0200, '0, 1'b1, 32'h0, 1'b1, 1, 0, 0, "R6 sram fetch");
      run(2'b10, 32'h4200_0428, '0, 1'b1, 32'h0, 1'b1, 1, 0, 0, "R6 periph fetch");

      // addresses just outside the windows pass through (R1)
      pwrite(32'h21FF_FFF0, 32'hA5A5_0001);
      pread(32'h21FF_FFF0, 32'hA5A5_0001, "R1 below window");
      pwrite(32'h2400_0000, 32'h1234_5678);
      pread(32'h2400_0000, 32'h1234_5678, "R1 above window");
      run(2'b10, 32'h2400_0000, '0, 1'b1, 32'h1234_5678, 1'b0, 1, 1, 0, "R1 fetch outside");

      // wait states (R7, R8)
      wait_cfg = 2;
      pread(32'h2000_0010, 32'h0008_8000, "R8 pass read wait");
      run(2'b00, 32'h2200_024C, '0, 1'b1, 32'h1, 1'b0, 4, 1, 0, "R7 read wait");
      run(2'b01, 32'h2200_024C, 32'h0, 1'b1, 32'h0, 1'b0, 7, 2, 2, "R7 write wait");
      pread(32'h2000_0010, 32'h0000_8000, "R7 after wait write");
      wait_cfg = 0;

      @(negedge clk);
      check("R9 idle mem_valid", {31'b0, mem_valid}, 32'h0);
      check("R9 idle mem_lock",  {31'b0, mem_lock},  32'h0);
      check("R3 scoreboard drained", sbq.size(), 0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule